// File: doc/BRIEF.md
# Two-Wire GPIO Expander Target

This block is a two-wire serial (I2C) target that puts eight general-purpose I/O bits behind a register file of eight byte-wide registers. A host selects the block with a 7-bit target address. The low bit of that address comes from a strap input, so two copies of the block can share one bus. The block also accepts a shared broadcast address for writes, so one transaction can program several copies at once. After the address, the first byte of a write is a command byte. It picks the register that the following data bytes write, and that a later read returns.

The registers set pin direction, the driven output level, per-pin input inversion, bus-hold, and pull-resistor selection. The block drives per-pin output-enable and output-value signals, a per-pin pull enable and pull-up select, and a bank-wide bus-hold enable, all towards an external pad ring. A separate interrupt block reads the interrupt mask register on a dedicated output and supplies the interrupt status byte that software reads back.

The SCL and SDA inputs are expected to be already synchronised and deglitched. SDA is driven open-drain: while `sda_oe_o` is high, the pad pulls the line low.

Top module: `gpx_expander`

## Requirements
- R1: Only bits [2:0] of the command byte select the register (0 input, 1 polarity, 2 hold/pull control, 3 pull select, 4 direction, 5 output, 6 interrupt mask, 7 interrupt status). Bits [7:3] are ignored. Every data byte of a write goes to that same register, and the selection persists for later reads.
- R2: After a synchronous reset, direction is 0xFF (a 1 bit means input), polarity, hold/pull control, pull select and output are 0x00, and the interrupt mask is 0xFF. `pin_oe_o`, `pin_out_o`, `pull_en_o`, `pull_up_o`, `hold_en_o` and `sda_oe_o` are all low.
- R3: A direction bit of 0 raises `pin_oe_o` for that pin, and a 1 lowers it. Each bit acts independently.
- R4: Reading register 0 returns `pin_i` XOR the polarity register.
- R5: Reading register 5 returns the stored output byte. `pin_out_o` equals that byte masked by `pin_oe_o`, so output bits of input pins have no effect.
- R6: When bit 0 of the hold/pull control register is 1, `hold_en_o` is high and every `pull_en_o` bit is low, whatever bit 1 holds.
- R7: When control bit 0 is 0 and bit 1 is 1, all `pull_en_o` bits are high and `pull_up_o` equals the pull select register (1 means pull-up, 0 means pull-down). In every other case `pull_up_o` is 0.
- R8: Writes to registers 0 and 7 are acknowledged and change nothing. Register 7 reads `irq_status_i`. Register 6 is read/write and drives `irq_mask_o`.
- R9: The target acknowledges the address {ADDR_HI, `addr_sel_i`} in either direction. For any other address except the broadcast write, it leaves SDA released during the acknowledge slot.
- R10: The broadcast address ALLCALL_ADDR is acknowledged for writes, which update registers as normal. A read to it is not acknowledged.
- R11: A START or STOP at any point releases SDA on the next clock. A START makes the block wait for a new address.
- R12: Read data goes out MSB first. A host ACK makes the block send the same register again. A host NACK ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe_o | output | 1 | High pulls SDA low |
| addr_sel_i | input | 1 | Strap for the low target address bit |
| pin_i | input | 8 | Pad input levels |
| irq_status_i | input | 8 | Status byte from the interrupt block |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin driven level |
| pull_en_o | output | 8 | Per-pin pull resistor enable |
| pull_up_o | output | 8 | Per-pin pull-up (1) or pull-down (0) select |
| hold_en_o | output | 1 | Bank-wide bus-hold enable |
| irq_mask_o | output | 8 | Interrupt mask register contents |

## Verification
The bench keeps the default parameters: ADDR_HI is 6'b010000, which gives target addresses 0x20 and 0x21, and ALLCALL_ADDR is 0x68. The strap moves the block between the two addresses, and both can be checked against a neighbour address that must be refused. The broadcast address lies far from both, so a write to it can only land through the broadcast path. Read data comes back over the bus with no shortcut.

// File: rtl/gpx_pkg.sv
// Shared types for the GPIO expander target.
// Assumes a byte-wide register file addressed by a 3-bit pointer.
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 3;

    // Register selector values; the numbering is the host-visible map.
    typedef enum logic [PTR_W-1:0] {
        REG_INPUT    = 3'd0,
        REG_POLARITY = 3'd1,
        REG_PULLCTL  = 3'd2,
        REG_PULLSEL  = 3'd3,
        REG_DIR      = 3'd4,
        REG_OUTPUT   = 3'd5,
        REG_IRQMASK  = 3'd6,
        REG_IRQSTAT  = 3'd7
    } reg_idx_e;

    // Serial protocol states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        RX_ADDR,
        RX_CMD,
        RX_DATA
    } rx_kind_e;
endpackage

// File: rtl/gpx_line_monitor.sv
// Detects bus conditions on the two-wire lines.
// Assumes scl_i and sda_i are already synchronised to clk and free of glitches.
module gpx_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels for edge detection; idle lines read high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the current sample against the previous one.
    always_comb begin
        scl_rise_o = !scl_q && scl_i;
        scl_fall_o = scl_q && !scl_i;
        start_o    = scl_q && scl_i && sda_q && !sda_i;
        stop_o     = scl_q && scl_i && !sda_q && sda_i;
    end
endmodule

// File: rtl/gpx_bus_fsm.sv
// Byte-level protocol engine of the target: address match, command pointer,
// write strobes and read shifting. Assumes the event inputs from
// gpx_line_monitor. rd_data_i is sampled on the SCL fall that starts a byte.
module gpx_bus_fsm
    import gpx_pkg::*;
#(
    parameter logic [5:0] ADDR_HI      = 6'b010000,
    parameter logic [6:0] ALLCALL_ADDR = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_state_e          state;
    rx_kind_e            kind;
    logic [BYTE_W-2:0]   sr;
    logic [BYTE_W-2:0]   tx;
    logic [CNT_W-1:0]    cnt;
    logic                go_tx;
    logic [BYTE_W-1:0]   rx_byte;
    logic [6:0]          own_addr;
    logic                addr_hit;

    // Assemble the byte completing on this SCL rise and decode the address.
    always_comb begin
        rx_byte  = {sr, sda_i};
        own_addr = {ADDR_HI, addr_sel_i};
        addr_hit = (rx_byte[7:1] == own_addr) ||
                   ((rx_byte[7:1] == ALLCALL_ADDR) && !rx_byte[0]);
    end

    // Protocol sequencer; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= RX_ADDR;
            sr        <= '0;
            tx        <= '0;
            cnt       <= '0;
            go_tx     <= 1'b0;
            sda_oe_o  <= 1'b0;
            ptr_o     <= '0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_i) begin
                state    <= ST_RX;
                kind     <= RX_ADDR;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_i) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: ;
                    ST_RX: if (scl_rise_i) begin
                        sr  <= rx_byte[BYTE_W-2:0];
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == LAST_BIT) begin
                            state <= ST_ACK_SETUP;
                            go_tx <= 1'b0;
                            case (kind)
                                RX_ADDR: begin
                                    if (addr_hit) begin
                                        go_tx <= rx_byte[0];
                                        kind  <= RX_CMD;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_CMD: begin
                                    ptr_o <= rx_byte[PTR_W-1:0];
                                    kind  <= RX_DATA;
                                end
                                default: begin
                                    wr_en_o   <= 1'b1;
                                    wr_data_o <= rx_byte;
                                end
                            endcase
                        end
                    end
                    ST_ACK_SETUP: if (scl_fall_i) begin
                        sda_oe_o <= 1'b1;
                        state    <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (scl_fall_i) begin
                        cnt <= '0;
                        if (go_tx) begin
                            tx       <= rd_data_i[BYTE_W-2:0];
                            sda_oe_o <= !rd_data_i[BYTE_W-1];
                            state    <= ST_TX;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall_i) begin
                        if (cnt == LAST_BIT) begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_TX_ACK;
                        end else begin
                            sda_oe_o <= !tx[BYTE_W-2];
                            tx       <= {tx[BYTE_W-3:0], 1'b0};
                            cnt      <= cnt + CNT_W'(1);
                        end
                    end
                    ST_TX_ACK: if (scl_rise_i) begin
                        if (!sda_i) begin
                            go_tx <= 1'b1;
                            state <= ST_ACK_HOLD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: a STOP frees the data line on the next clock.
    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_oe_o);
    // R11: a START frees the data line on the next clock.
    assert_release_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !sda_oe_o);
    // R9: SDA is pulled only inside an acknowledge slot or a read byte.
    assert_drive_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state == ST_ACK_HOLD || state == ST_TX));
    // R1: a write strobe follows a completed byte that arrived as data.
    assert_strobe_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (state == ST_ACK_SETUP && $past(scl_rise_i)));
endmodule

// File: rtl/gpx_regs.sv
// Register file and pin control for the GPIO expander.
// Assumes one write strobe per received data byte. The read mux is
// combinational on the pointer.
module gpx_regs
    import gpx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DIR_RESET  = 8'hFF,
    parameter logic [BYTE_W-1:0] MASK_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] pin_i,
    input  logic [BYTE_W-1:0] irq_status_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] pin_oe_o,
    output logic [BYTE_W-1:0] pin_out_o,
    output logic [BYTE_W-1:0] pull_en_o,
    output logic [BYTE_W-1:0] pull_up_o,
    output logic              hold_en_o,
    output logic [BYTE_W-1:0] irq_mask_o
);
    logic [BYTE_W-1:0] pol_q, ctl_q, sel_q, dir_q, out_q, mask_q;
    logic              pull_on;

    // Writable registers; writes to the input and status registers are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            ctl_q  <= '0;
            sel_q  <= '0;
            dir_q  <= DIR_RESET;
            out_q  <= '0;
            mask_q <= MASK_RESET;
        end else if (wr_en_i) begin
            case (reg_idx_e'(ptr_i))
                REG_POLARITY: pol_q  <= wr_data_i;
                REG_PULLCTL:  ctl_q  <= wr_data_i;
                REG_PULLSEL:  sel_q  <= wr_data_i;
                REG_DIR:      dir_q  <= wr_data_i;
                REG_OUTPUT:   out_q  <= wr_data_i;
                REG_IRQMASK:  mask_q <= wr_data_i;
                default: ;
            endcase
        end
    end

    // Read mux; the input register applies the polarity inversion.
    always_comb begin
        case (reg_idx_e'(ptr_i))
            REG_INPUT:    rd_data_o = pin_i ^ pol_q;
            REG_POLARITY: rd_data_o = pol_q;
            REG_PULLCTL:  rd_data_o = ctl_q;
            REG_PULLSEL:  rd_data_o = sel_q;
            REG_DIR:      rd_data_o = dir_q;
            REG_OUTPUT:   rd_data_o = out_q;
            REG_IRQMASK:  rd_data_o = mask_q;
            default:      rd_data_o = irq_status_i;
        endcase
    end

    // Bank-wide hold/pull decode: hold wins over the pull resistors.
    always_comb begin
        hold_en_o  = ctl_q[0];
        pull_on    = ctl_q[1] && !ctl_q[0];
        irq_mask_o = mask_q;
    end

    // Per-pin drive and pull controls.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_pin
        assign pin_oe_o[g]  = !dir_q[g];
        assign pin_out_o[g] = out_q[g] && !dir_q[g];
        assign pull_en_o[g] = pull_on;
        assign pull_up_o[g] = pull_on && sel_q[g];
    end

    // R3: a direction write turns into output enables on the next clock.
    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_idx_e'(ptr_i) == REG_DIR) |=> (pin_oe_o == ~$past(wr_data_i)));
    // R5: an output write reaches only the enabled pins.
    assert_out_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_idx_e'(ptr_i) == REG_OUTPUT) |=> (pin_out_o == ($past(wr_data_i) & pin_oe_o)));
    // R6: enabling hold switches every pull resistor off.
    assert_hold_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_idx_e'(ptr_i) == REG_PULLCTL && wr_data_i[0]) |=> (hold_en_o && pull_en_o == '0));
    // R8: writes to read-only registers leave every control output unchanged.
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (reg_idx_e'(ptr_i) == REG_INPUT || reg_idx_e'(ptr_i) == REG_IRQSTAT))
        |=> ($stable(pin_oe_o) && $stable(pin_out_o) && $stable(pull_en_o) &&
             $stable(pull_up_o) && $stable(hold_en_o) && $stable(irq_mask_o)));
endmodule

// File: rtl/gpx_expander.sv
// Top of the two-wire GPIO expander target: line monitor, protocol engine
// and register file. Assumes synchronised, deglitched SCL/SDA inputs and
// an external open-drain pad driven by sda_oe_o.
module gpx_expander
    import gpx_pkg::*;
#(
    parameter logic [5:0] ADDR_HI      = 6'b010000,
    parameter logic [6:0] ALLCALL_ADDR = 7'h68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       addr_sel_i,
    input  logic [7:0] pin_i,
    input  logic [7:0] irq_status_i,
    output logic [7:0] pin_oe_o,
    output logic [7:0] pin_out_o,
    output logic [7:0] pull_en_o,
    output logic [7:0] pull_up_o,
    output logic       hold_en_o,
    output logic [7:0] irq_mask_o
);
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    gpx_line_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    gpx_bus_fsm #(
        .ADDR_HI      (ADDR_HI),
        .ALLCALL_ADDR (ALLCALL_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_i      (sda_i),
        .addr_sel_i (addr_sel_i),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data)
    );

    gpx_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .ptr_i        (ptr),
        .wr_data_i    (wr_data),
        .pin_i        (pin_i),
        .irq_status_i (irq_status_i),
        .rd_data_o    (rd_data),
        .pin_oe_o     (pin_oe_o),
        .pin_out_o    (pin_out_o),
        .pull_en_o    (pull_en_o),
        .pull_up_o    (pull_up_o),
        .hold_en_o    (hold_en_o),
        .irq_mask_o   (irq_mask_o)
    );
endmodule

// File: tb/gpx_expander_bench.sv
// Self-checking bench: a vector table of register write/read pairs, then
// directed tests for reset, addressing, broadcast, aborts and bursts.
module gpx_expander_bench;
    localparam int Q = 4;
    localparam logic [6:0] OWN0 = 7'h20;
    localparam logic [6:0] OWN1 = 7'h21;
    localparam logic [6:0] BCAST = 7'h68;

    typedef struct packed {
        logic [7:0] wcmd;
        logic [7:0] wdat;
        logic [7:0] pins;
        logic [7:0] rcmd;
        logic [7:0] expv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h00, 8'h5A, 8'h00, 8'h5A, 8'd4},  // R4 no inversion
        '{8'h01, 8'hF0, 8'h5A, 8'h00, 8'hAA, 8'd4},  // R4 upper nibble inverted
        '{8'h04, 8'h0F, 8'h00, 8'h04, 8'h0F, 8'd3},  // R3 direction readback
        '{8'h05, 8'h96, 8'h00, 8'h05, 8'h96, 8'd5},  // R5 stored value, not pins
        '{8'h03, 8'h3C, 8'h00, 8'h03, 8'h3C, 8'd7},  // R7 pull select
        '{8'h02, 8'h02, 8'h00, 8'h02, 8'h02, 8'd7},  // R7 pulls on
        '{8'h06, 8'h81, 8'h00, 8'h06, 8'h81, 8'd8},  // R8 mask read/write
        '{8'h00, 8'hFF, 8'h11, 8'h00, 8'hE1, 8'd8},  // R8 input write ignored
        '{8'h07, 8'hFF, 8'h11, 8'h07, 8'h24, 8'd8},  // R8 status write ignored
        '{8'h0D, 8'h77, 8'h11, 8'h05, 8'h77, 8'd1},  // R1 upper command bits ignored
        '{8'h05, 8'h33, 8'h11, 8'hF5, 8'h33, 8'd1}   // R1 read with upper bits set
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] pins = 8'h00;
    logic [7:0] irq_status = 8'h24;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] pin_oe, pin_out, pull_en, pull_up, irq_mask;
    logic       hold_en;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    assign sda_bus = sda_m && !sda_oe;

    always #2.5 clk = ~clk;

    gpx_expander u_gpx_expander (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .addr_sel_i   (addr_sel),
        .pin_i        (pins),
        .irq_status_i (irq_status),
        .pin_oe_o     (pin_oe),
        .pin_out_o    (pin_out),
        .pull_en_o    (pull_en),
        .pull_up_o    (pull_up),
        .hold_en_o    (hold_en),
        .irq_mask_o   (irq_mask)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        nack = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic host_nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus; wq();
            scl_m = 1'b0;
        end
        wq();
        sda_m = host_nack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                          output logic ok);
        logic n1, n2, n3;
        n2 = 1'b1; n3 = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, n1);
        if (!n1) begin
            send_byte(cmd, n2);
            send_byte(d, n3);
        end
        bus_stop();
        ok = !n1 && !n2 && !n3;
    endtask

    task automatic rd_reg(input logic [6:0] a, input logic [7:0] cmd,
                          output logic [7:0] d, output logic ok);
        logic n1, n2, n3;
        d = 8'h00; n2 = 1'b1; n3 = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, n1);
        if (!n1) send_byte(cmd, n2);
        bus_start();
        send_byte({a, 1'b1}, n3);
        if (!n3) recv_byte(1'b1, d);
        bus_stop();
        ok = !n1 && !n2 && !n3;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_reset_state(input string tag);
        logic [7:0] d;
        logic ok;
        chk(pin_oe, 8'h00, {tag, " R2 pin_oe"});
        chk(pin_out, 8'h00, {tag, " R2 pin_out"});
        chk(pull_en, 8'h00, {tag, " R2 pull_en"});
        chk(pull_up, 8'h00, {tag, " R2 pull_up"});
        chk({7'd0, hold_en}, 8'h00, {tag, " R2 hold_en"});
        chk(irq_mask, 8'hFF, {tag, " R2 irq_mask"});
        chk({7'd0, sda_oe}, 8'h00, {tag, " R2 sda_oe"});
        rd_reg(OWN0, 8'h04, d, ok);
        chk(d, 8'hFF, {tag, " R2 direction reset"});
        rd_reg(OWN0, 8'h05, d, ok);
        chk(d, 8'h00, {tag, " R2 output reset"});
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic ok, nk;
        logic [7:0] d, d2;
        do_reset();
        chk_reset_state("initial");

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            pins = VECS[i].pins;
            wr_reg(OWN0, VECS[i].wcmd, VECS[i].wdat, ok);
            chk({7'd0, ok}, 8'h01, $sformatf("R%0d vector %0d write ack", VECS[i].req, i));
            rd_reg(OWN0, VECS[i].rcmd, d, ok);
            chk(d, VECS[i].expv, $sformatf("R%0d vector %0d readback", VECS[i].req, i));
        end

        // Pin controls after the table: dir 0F, out 33, ctl 02, sel 3C, mask 81.
        chk(pin_oe, 8'hF0, "R3 pin_oe from direction");
        chk(pin_out, 8'h30, "R5 output masked by direction");
        chk(pull_en, 8'hFF, "R7 pulls enabled");
        chk(pull_up, 8'h3C, "R7 pull-up select");
        chk({7'd0, hold_en}, 8'h00, "R7 hold off");
        chk(irq_mask, 8'h81, "R8 mask output");

        // R6: hold overrides the pulls.
        wr_reg(OWN0, 8'h02, 8'h03, ok);
        chk({7'd0, hold_en}, 8'h01, "R6 hold on");
        chk(pull_en, 8'h00, "R6 pulls off under hold");
        chk(pull_up, 8'h00, "R6 pull-up off under hold");

        // R1: two data bytes in one write go to the same register.
        bus_start();
        send_byte({OWN0, 1'b0}, nk);
        send_byte(8'h01, nk);
        send_byte(8'hAA, nk);
        send_byte(8'h0F, nk);
        bus_stop();
        rd_reg(OWN0, 8'h01, d, ok);
        chk(d, 8'h0F, "R1 burst write lands on one register");

        // R12: burst read repeats the same register until host NACK.
        bus_start();
        send_byte({OWN0, 1'b0}, nk);
        send_byte(8'h05, nk);
        bus_start();
        send_byte({OWN0, 1'b1}, nk);
        recv_byte(1'b0, d);
        recv_byte(1'b1, d2);
        chk({7'd0, sda_oe}, 8'h00, "R12 line released after host NACK");
        bus_stop();
        chk(d, 8'h33, "R12 first read byte");
        chk(d2, 8'h33, "R12 second read byte");

        // R9: address matching and the strap.
        bus_start();
        send_byte({7'h22, 1'b0}, nk);
        bus_stop();
        chk({7'd0, nk}, 8'h01, "R9 foreign address refused");
        bus_start();
        send_byte({OWN1, 1'b0}, nk);
        bus_stop();
        chk({7'd0, nk}, 8'h01, "R9 strap-low refuses 0x21");
        addr_sel = 1'b1;
        wq();
        wr_reg(OWN1, 8'h06, 8'h5A, ok);
        chk({7'd0, ok}, 8'h01, "R9 strap-high accepts 0x21");
        chk(irq_mask, 8'h5A, "R9 write through strap address");
        addr_sel = 1'b0;
        wq();

        // R10: broadcast write accepted, broadcast read refused.
        wr_reg(BCAST, 8'h05, 8'h5C, ok);
        chk({7'd0, ok}, 8'h01, "R10 broadcast write ack");
        rd_reg(OWN0, 8'h05, d, ok);
        chk(d, 8'h5C, "R10 broadcast write effect");
        bus_start();
        send_byte({BCAST, 1'b1}, nk);
        bus_stop();
        chk({7'd0, nk}, 8'h01, "R10 broadcast read refused");

        // R11: a START in mid-byte aborts and the next transfer works.
        bus_start();
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        wr_reg(OWN0, 8'h03, 8'hC3, ok);
        chk({7'd0, ok}, 8'h01, "R11 write after aborted byte");
        chk({7'd0, sda_oe}, 8'h00, "R11 line free after STOP");
        rd_reg(OWN0, 8'h03, d, ok);
        chk(d, 8'hC3, "R11 data after aborted byte");

        // R2: reset in mid-run restores defaults.
        do_reset();
        chk_reset_state("mid-run");

        done = 1'b1;
        report();
        $finish;
    end
endmodule